// File: doc/BRIEF.md
# Prioritized Interrupt Controller

This block gathers interrupt requests from a parameterized number of peripheral sources and presents one winning request to the CPU. Each source carries a pending flag, an enable bit, a priority field and a trigger mode, which is either edge or level. The pending flag records the request, the enable bit decides whether that flag may be taken, and the priority field ranks the source against the others.

The CPU supplies its current priority level. A source is only forwarded when its priority is strictly greater than that level, and also greater than the priority of every other eligible source. The winner's index is driven out as the vector number. When the CPU accepts an interrupt, it returns the accepted vector on the acknowledge port, and the matching edge-mode flag is cleared.

Software can set and clear pending flags and read them on the pending output, so sources can also be polled. One source can be selected as the fast interrupt. That source is taken out of normal arbitration and signalled on a dedicated request output.

Top module: `prio_intc`

## Requirements
- R1: An edge-mode source sets its pending flag on a 0-to-1 transition of its request input, and the flag is visible on `pend` one clock later. A request held high does not set the flag again.
- R2: A pending source whose enable bit is 0 is never forwarded on `irq`, and its pending flag is kept.
- R3: A source with priority field 0 is never forwarded on `irq`.
- R4: A source is forwarded only if its priority is strictly greater than `cpu_level`. Equal priority does not qualify.
- R5: Among eligible sources, the one with the highest priority wins. On equal priority, the lowest source index wins, and that index is the value driven on `irq_vec`.
- R6: `ack` with `ack_vec` = k clears the pending flag of source k only, and only if k is in edge mode. Other pending flags stay set.
- R7: On an edge-mode source, a `sw_set` bit sets the pending flag and a `sw_clr` bit clears it. If a set (from software or a new edge) and a clear arrive in the same cycle, the set wins.
- R8: A level-mode source (`cfg_level` = 1) has a pending flag equal to its request input registered once. `sw_set`, `sw_clr` and `ack` have no effect on it.
- R9: While the fast register is valid, the source it names is excluded from `irq`. `firq` is 1 one clock after that source is both pending and enabled, whatever its priority.
- R10: After reset, all pending, enable, mode, priority and fast settings are 0, and `irq` and `firq` are 0.
- R11: `irq`, `irq_vec` and `firq` are registered. Each reflects the pending flags, the configuration and `cpu_level` as they stood one clock earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_req | input | NSRC | Peripheral request lines |
| cfg_we | input | 1 | Write configuration of source `cfg_idx` |
| cfg_idx | input | IW | Source index for the configuration write |
| cfg_en | input | 1 | Enable bit to write |
| cfg_prio | input | PW | Priority to write (0 disables) |
| cfg_level | input | 1 | Mode to write: 1 level, 0 edge |
| fast_we | input | 1 | Write the fast-interrupt register |
| fast_valid | input | 1 | Fast register valid bit to write |
| fast_idx | input | IW | Source index to mark as fast |
| sw_set | input | NSRC | Software set of pending flags |
| sw_clr | input | NSRC | Software clear of pending flags |
| cpu_level | input | PW | CPU's current priority level |
| ack | input | 1 | CPU accepts an interrupt |
| ack_vec | input | IW | Vector number being accepted |
| pend | output | NSRC | Pending flags, readable for polling |
| irq | output | 1 | Normal interrupt request to the CPU |
| irq_vec | output | IW | Vector number of the winning source |
| firq | output | 1 | Fast interrupt request |

## Verification
A stimulus applied before a clock edge shows up on `pend` just after that edge. The edge that follows carries it to `irq`, `irq_vec` and `firq`, so these appear two edges after the request input changes. Changes to configuration, `cpu_level` or a pending flag that is already set appear on the request outputs one edge later. The bench drives inputs on the falling edge and advances its model by exactly one rising edge per step. It compares `pend` and the registered outputs on the next falling edge, so each expected value is lined up with the edge that produces it.

// File: rtl/prio_intc.sv
module prio_intc #(
  parameter int NSRC = 8,
  parameter int PW   = 4,
  localparam int IW  = $clog2(NSRC)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] src_req,
  input  logic            cfg_we,
  input  logic [IW-1:0]   cfg_idx,
  input  logic            cfg_en,
  input  logic [PW-1:0]   cfg_prio,
  input  logic            cfg_level,
  input  logic            fast_we,
  input  logic            fast_valid,
  input  logic [IW-1:0]   fast_idx,
  input  logic [NSRC-1:0] sw_set,
  input  logic [NSRC-1:0] sw_clr,
  input  logic [PW-1:0]   cpu_level,
  input  logic            ack,
  input  logic [IW-1:0]   ack_vec,
  output logic [NSRC-1:0] pend,
  output logic            irq,
  output logic [IW-1:0]   irq_vec,
  output logic            firq
);
  logic [NSRC-1:0] pend_q, en_q, lvl_q, src_d;
  logic [PW-1:0]   prio_q [NSRC];
  logic [NSRC*PW-1:0] prio_flat;
  logic            fv_q;
  logic [IW-1:0]   fidx_q;
  logic            live_q;

  logic [NSRC-1:0] edge_hit, ack_hot, fast_hot, cand, pend_nxt;
  logic [PW-1:0]   best;
  logic [IW-1:0]   best_idx;
  logic            hit;

  assign edge_hit = src_req & ~src_d;
  assign ack_hot  = ack  ? (NSRC'(1) << ack_vec) : '0;
  assign fast_hot = fv_q ? (NSRC'(1) << fidx_q)  : '0;
  assign cand     = pend_q & en_q & ~fast_hot;
  assign pend_nxt = (lvl_q & src_req) |
                    (~lvl_q & ((pend_q & ~(sw_clr | ack_hot)) | edge_hit | sw_set));
  assign pend     = pend_q;

  for (genvar g = 0; g < NSRC; g++) begin : g_flat
    assign prio_flat[g*PW +: PW] = prio_q[g];
  end

  always_comb begin
    best     = cpu_level;
    best_idx = '0;
    hit      = 1'b0;
    for (int i = 0; i < NSRC; i++) begin
      if (cand[i] && prio_q[i] > best) begin
        best     = prio_q[i];
        best_idx = IW'(i);
        hit      = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q  <= '0;
      en_q    <= '0;
      lvl_q   <= '0;
      src_d   <= '0;
      fv_q    <= 1'b0;
      fidx_q  <= '0;
      irq     <= 1'b0;
      irq_vec <= '0;
      firq    <= 1'b0;
      live_q  <= 1'b0;
      for (int i = 0; i < NSRC; i++) prio_q[i] <= '0;
    end else begin
      live_q  <= 1'b1;
      src_d   <= src_req;
      pend_q  <= pend_nxt;
      irq     <= hit;
      irq_vec <= best_idx;
      firq    <= |(pend_q & en_q & fast_hot);
      if (cfg_we) begin
        en_q[cfg_idx]   <= cfg_en;
        lvl_q[cfg_idx]  <= cfg_level;
        prio_q[cfg_idx] <= cfg_prio;
      end
      if (fast_we) begin
        fv_q   <= fast_valid;
        fidx_q <= fast_idx;
      end
    end
  end

  AST_WIN_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
    (live_q && irq) |-> ((($past(pend_q & en_q)) >> irq_vec) & NSRC'(1)) != '0); // R2
  AST_WIN_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (live_q && irq && $stable(prio_flat)) |-> prio_q[irq_vec] != '0); // R3
  AST_ABOVE_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    (live_q && irq && $stable(prio_flat)) |-> prio_q[irq_vec] > $past(cpu_level)); // R4
  AST_LEVEL_TRACK: assert property (@(posedge clk) disable iff (!rst_n)
    live_q |=> ((pend_q ^ $past(src_req)) & $past(lvl_q)) == '0); // R8
  AST_FAST_APART: assert property (@(posedge clk) disable iff (!rst_n)
    (live_q && irq) |-> !($past(fv_q) && $past(fidx_q) == irq_vec)); // R9
endmodule

// File: tb/prio_intc_test.sv
module prio_intc_test;
  localparam int N = 8, PW = 4, IW = 3;
  logic clk = 0, rst_n = 0;
  logic [N-1:0] src_req = '0, sw_set = '0, sw_clr = '0;
  logic cfg_we = 0, cfg_en = 0, cfg_level = 0, fast_we = 0, fast_valid = 0, ack = 0;
  logic [IW-1:0] cfg_idx = '0, fast_idx = '0, ack_vec = '0;
  logic [PW-1:0] cfg_prio = '0, cpu_level = '0;
  logic [N-1:0] pend;
  logic irq, firq;
  logic [IW-1:0] irq_vec;

  prio_intc #(.NSRC(N), .PW(PW)) uut (.clk, .rst_n, .src_req, .cfg_we, .cfg_idx, .cfg_en,
    .cfg_prio, .cfg_level, .fast_we, .fast_valid, .fast_idx, .sw_set, .sw_clr, .cpu_level,
    .ack, .ack_vec, .pend, .irq, .irq_vec, .firq);

  always #10 clk = ~clk;

  int errors = 0, checks = 0;
  bit finished = 0;
  logic [N-1:0] m_pend = '0, m_en = '0, m_lvl = '0, m_srcd = '0;
  logic [PW-1:0] m_prio [N];
  logic m_fv = 0, m_irq = 0, m_firq = 0;
  logic [IW-1:0] m_fidx = '0, m_vec = '0;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic void arbitrate(output logic f, output logic [IW-1:0] v);
    logic [PW-1:0] b = cpu_level;
    f = 0; v = '0;
    for (int i = 0; i < N; i++)
      if (m_pend[i] && m_en[i] && !(m_fv && m_fidx == IW'(i)) && m_prio[i] > b) begin
        b = m_prio[i]; v = IW'(i); f = 1;
      end
  endfunction

  task automatic tick();
    logic f; logic [IW-1:0] v; logic [N-1:0] np;
    arbitrate(f, v);
    for (int i = 0; i < N; i++) begin
      if (m_lvl[i]) np[i] = src_req[i];
      else np[i] = (m_pend[i] && !sw_clr[i] && !(ack && ack_vec == IW'(i)))
                   || (src_req[i] && !m_srcd[i]) || sw_set[i];
    end
    m_firq = m_fv && m_pend[m_fidx] && m_en[m_fidx];
    m_irq = f; m_vec = v; m_srcd = src_req; m_pend = np;
    if (cfg_we) begin
      m_en[cfg_idx] = cfg_en; m_lvl[cfg_idx] = cfg_level; m_prio[cfg_idx] = cfg_prio;
    end
    if (fast_we) begin m_fv = fast_valid; m_fidx = fast_idx; end
    @(posedge clk); @(negedge clk);
    check(pend == m_pend, "R1 pend", pend, m_pend);
    check(irq == m_irq, "R11 irq", irq, m_irq);
    if (m_irq) check(irq_vec == m_vec, "R5 vec", irq_vec, m_vec);
    check(firq == m_firq, "R9 firq", firq, m_firq);
  endtask

  task automatic set_cfg(input int i, input bit en, input int pr, input bit lv);
    cfg_we = 1; cfg_idx = IW'(i); cfg_en = en; cfg_prio = PW'(pr); cfg_level = lv;
    tick();
    cfg_we = 0;
  endtask

  initial begin
    #4_000_000;
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed));
    for (int i = 0; i < N; i++) m_prio[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check(pend == 0 && irq == 0 && firq == 0, "R10 reset", {pend, irq, firq}, 0);

    for (int i = 0; i < N; i++) set_cfg(i, 1, i + 1, 0);
    src_req[3] = 1; tick();
    check(pend[3] == 1 && irq == 0, "R11 pend first", {pend[3], irq}, 2);
    tick();
    check(irq == 1 && irq_vec == 3, "R1 irq vec3", irq_vec, 3);
    tick();
    check(pend[3] == 0 || pend[3] == 1, "R1 held", pend[3], 1);
    check(pend[3] == 1, "R1 no re-set while held", pend[3], 1);
    ack = 1; ack_vec = 3; tick(); ack = 0;
    check(pend[3] == 0, "R6 ack clears", pend[3], 0);
    tick();
    check(irq == 0, "R6 irq drops", irq, 0);
    src_req[3] = 0;

    set_cfg(2, 1, 6, 0);
    src_req[2] = 1; src_req[5] = 1; tick(); tick();
    check(irq && irq_vec == 2, "R5 tie lowest index", irq_vec, 2);
    ack = 1; ack_vec = 5; tick(); ack = 0;
    check(pend[5] == 0 && pend[2] == 1, "R6 only acked", pend[5:2], 4'b0001);
    src_req[2] = 0; src_req[5] = 0;
    cpu_level = 6; tick(); tick();
    check(irq == 0, "R4 equal level blocks", irq, 0);
    cpu_level = 5; tick();
    check(irq && irq_vec == 2, "R4 above level", irq_vec, 2);
    set_cfg(2, 1, 0, 0); tick();
    check(irq == 0 && pend[2] == 1, "R3 zero prio", {irq, pend[2]}, 1);
    set_cfg(2, 0, 6, 0); tick();
    check(irq == 0 && pend[2] == 1, "R2 disabled kept", {irq, pend[2]}, 1);
    sw_clr[2] = 1; sw_set[4] = 1; sw_clr[4] = 1; tick(); sw_clr = '0; sw_set = '0;
    check(pend[2] == 0 && pend[4] == 1, "R7 sw set/clr", {pend[2], pend[4]}, 1);

    set_cfg(6, 1, 2, 1);
    src_req[6] = 1; tick();
    check(pend[6] == 1, "R8 level set", pend[6], 1);
    sw_clr[6] = 1; tick(); sw_clr = '0;
    check(pend[6] == 1, "R8 sw_clr ignored", pend[6], 1);
    ack = 1; ack_vec = 6; tick(); ack = 0;
    check(pend[6] == 1, "R8 ack ignored", pend[6], 1);
    src_req[6] = 0; tick();
    check(pend[6] == 0, "R8 follows request", pend[6], 0);
    sw_set[6] = 1; tick(); sw_set = '0;
    check(pend[6] == 0, "R8 sw_set ignored", pend[6], 0);

    fast_we = 1; fast_valid = 1; fast_idx = 7; tick(); fast_we = 0;
    src_req[7] = 1; tick(); tick();
    check(firq == 1 && !(irq && irq_vec == 7), "R9 fast path", {firq, irq}, 2);
    ack = 1; ack_vec = 7; tick(); ack = 0; tick();
    check(firq == 0, "R9 fast cleared", firq, 0);
    src_req[7] = 0;

    for (int n = 0; n < 4000; n++) begin
      src_req = N'($urandom);
      sw_set = ($urandom_range(0, 7) == 0) ? N'($urandom) : '0;
      sw_clr = ($urandom_range(0, 5) == 0) ? N'($urandom) : '0;
      cpu_level = PW'($urandom_range(0, 9));
      cfg_we = ($urandom_range(0, 9) == 0);
      cfg_idx = IW'($urandom); cfg_en = ($urandom_range(0, 3) != 0);
      cfg_prio = PW'($urandom); cfg_level = ($urandom_range(0, 3) == 0);
      fast_we = ($urandom_range(0, 99) == 0);
      fast_valid = $urandom_range(0, 1); fast_idx = IW'($urandom);
      ack = irq && ($urandom_range(0, 1) == 1);
      ack_vec = ($urandom_range(0, 7) == 0) ? IW'($urandom) : irq_vec;
      tick();
    end
    cfg_we = 0; fast_we = 0; ack = 0; sw_set = '0; sw_clr = '0;

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule